// File: doc/BRIEF.md
# Rotating General Register File

This block is a general-purpose integer register file whose upper region is renamed through a rotating base. Software-pipelined loops can then name one logical register while each iteration's value lands in a different physical register. Logical registers below a fixed boundary map straight through to storage. Logical registers at or above the boundary are offset by a rotation base that moves up by one on each rotate strobe. The effect is that a value written under one logical name appears one name higher after every rotation. From the highest rotating name it wraps back to the lowest.

The file has two combinational read ports and one synchronous write port, and all three take logical register numbers. A clear strobe returns the rotation base to zero. Logical register zero is hard-wired to read as zero. With the default parameters there are 128 registers of 64 bits each: 32 static registers and 96 rotating ones.

Top module: `rot_gpr_file`

## Requirements
- R1: Logical registers 1 to STATIC_REGS-1 (default 31) map to physical registers of the same number whatever the rotation base is. Rotating or clearing never changes the value they read back.
- R2: Logical register 0 reads as zero on both read ports. A write to it is discarded, so it still reads zero afterwards.
- R3: A write with wr_en_i high stores wr_data_i under logical wr_addr_i at the rising clock edge. When no rotation or clear happens in that cycle, a read of the same logical number from the next cycle on returns the written data.
- R4: A cycle with rot_i high and clr_i low advances the rotation base by one, modulo ROT_REGS = NUM_REGS-STATIC_REGS. After one rotation, a value readable at logical n (n ≥ STATIC_REGS) is readable at logical STATIC_REGS + ((n-STATIC_REGS+1) mod ROT_REGS), so the top rotating name wraps to STATIC_REGS. With rot_i and clr_i both low the base holds.
- R5: For n ≥ STATIC_REGS the physical index is STATIC_REGS + ((n-STATIC_REGS+ROT_REGS-base) mod ROT_REGS). The base always stays below ROT_REGS.
- R6: A write in the same cycle as a rotation or a clear uses the mapping in effect before that cycle's base change.
- R7: Reads are combinational. A read of the register being written in the same cycle returns the old value until the clock edge.
- R8: A cycle with clr_i high sets the rotation base to zero, and clr_i takes precedence over rot_i in the same cycle.
- R9: Asserting rst_n low sets the rotation base to zero. Register contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the rotation base |
| rot_i | input | 1 | Rotate strobe: advance the base by one |
| clr_i | input | 1 | Clear strobe: base to zero, wins over rot_i |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | $clog2(NUM_REGS) | Logical write register number |
| wr_data_i | input | DATA_W | Write data |
| rd0_addr_i | input | $clog2(NUM_REGS) | Logical register number, read port 0 |
| rd0_data_o | output | DATA_W | Read data, port 0 |
| rd1_addr_i | input | $clog2(NUM_REGS) | Logical register number, read port 1 |
| rd1_data_o | output | DATA_W | Read data, port 1 |

## Verification
The bench builds the file with NUM_REGS=16, STATIC_REGS=4 and DATA_W=16, which leaves a rotating region of 12 names. At that size every logical register can be read on both ports after every rotation. More than a full revolution of the base is covered, including the wrap from the top name back to the bottom one. In the same short run the bench also drives the combined rotate-and-write, clear-and-rotate and mid-run reset cases, each at a non-zero base.

// File: rtl/rot_gpr_pkg.sv
package rot_gpr_pkg;

  // Operation applied to the rotation base in one cycle
  typedef enum logic [1:0] {
    BASE_HOLD = 2'd0,
    BASE_ADV  = 2'd1,
    BASE_CLR  = 2'd2
  } base_op_e;

endpackage

// File: rtl/rot_base_ctr.sv
module rot_base_ctr
  import rot_gpr_pkg::*;
#(
  parameter int ROT_REGS = 96,
  localparam int BW = $clog2(ROT_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  base_op_e      op,
  output logic [BW-1:0] base
);

  localparam logic [BW-1:0] TOP = BW'(ROT_REGS - 1);

  logic [BW-1:0] base_q, base_d;
  logic          base_en;

  always_comb begin
    base_d  = base_q;
    base_en = 1'b0;
    case (op)
      BASE_CLR: begin
        base_d  = '0;
        base_en = 1'b1;
      end
      BASE_ADV: begin
        base_d  = (base_q == TOP) ? '0 : base_q + 1'b1;
        base_en = 1'b1;
      end
      default: begin
        base_d  = base_q;
        base_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  assign base = base_q;

endmodule

// File: rtl/rot_map.sv
module rot_map #(
  parameter int NUM_REGS    = 128,
  parameter int STATIC_REGS = 32,
  localparam int ROT_REGS = NUM_REGS - STATIC_REGS,
  localparam int AW = $clog2(NUM_REGS),
  localparam int BW = $clog2(ROT_REGS),
  localparam int XW = AW + 1
) (
  input  logic [AW-1:0] log_addr,
  input  logic [BW-1:0] base,
  output logic [AW-1:0] phy_addr
);

  localparam logic [XW-1:0] S_X = XW'(STATIC_REGS);
  localparam logic [XW-1:0] R_X = XW'(ROT_REGS);

  logic [XW-1:0] log_x, base_x, off_x, phy_x;

  always_comb begin
    log_x  = XW'(log_addr);
    base_x = XW'(base);
    off_x  = log_x - S_X;
    if (log_x < S_X)
      phy_x = log_x;
    else if (off_x >= base_x)
      phy_x = S_X + off_x - base_x;
    else
      phy_x = S_X + off_x + R_X - base_x;
    phy_addr = phy_x[AW-1:0];
  end

endmodule

// File: rtl/rot_storage.sv
module rot_storage #(
  parameter int NUM_REGS = 128,
  parameter int DATA_W   = 64,
  parameter int NRD      = 2,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [AW-1:0]     ra [NRD],
  output logic [DATA_W-1:0] rd [NRD]
);

  logic [DATA_W-1:0] mem [NUM_REGS];

  // Entry 0 is never written and never read
  always_ff @(posedge clk) begin
    if (we && (wa != '0)) mem[wa] <= wd;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd[p] = (ra[p] == '0) ? '0 : mem[ra[p]];
  end

endmodule

// File: rtl/rot_gpr_file.sv
module rot_gpr_file
  import rot_gpr_pkg::*;
#(
  parameter int NUM_REGS    = 128,
  parameter int STATIC_REGS = 32,
  parameter int DATA_W      = 64,
  localparam int ROT_REGS = NUM_REGS - STATIC_REGS,
  localparam int AW = $clog2(NUM_REGS),
  localparam int BW = $clog2(ROT_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rot_i,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd0_addr_i,
  output logic [DATA_W-1:0] rd0_data_o,
  input  logic [AW-1:0]     rd1_addr_i,
  output logic [DATA_W-1:0] rd1_data_o
);

  localparam int NPORT = 3;  // read 0, read 1, write

  base_op_e          op;
  logic [BW-1:0]     rrb;
  logic [AW-1:0]     log_a [NPORT];
  logic [AW-1:0]     phy_a [NPORT];
  logic [AW-1:0]     rd_pa [2];
  logic [DATA_W-1:0] rd_d  [2];

  always_comb begin
    if (clr_i)      op = BASE_CLR;
    else if (rot_i) op = BASE_ADV;
    else            op = BASE_HOLD;
  end

  rot_base_ctr #(.ROT_REGS(ROT_REGS)) i_base (
    .clk  (clk),
    .rst_n(rst_n),
    .op   (op),
    .base (rrb)
  );

  assign log_a[0] = rd0_addr_i;
  assign log_a[1] = rd1_addr_i;
  assign log_a[2] = wr_addr_i;

  // All ports translate with the base of the current cycle
  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rot_map #(.NUM_REGS(NUM_REGS), .STATIC_REGS(STATIC_REGS)) i_map (
      .log_addr(log_a[p]),
      .base    (rrb),
      .phy_addr(phy_a[p])
    );
  end

  assign rd_pa[0] = phy_a[0];
  assign rd_pa[1] = phy_a[1];

  rot_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NRD(2)) i_store (
    .clk(clk),
    .we (wr_en_i),
    .wa (phy_a[2]),
    .wd (wr_data_i),
    .ra (rd_pa),
    .rd (rd_d)
  );

  assign rd0_data_o = rd_d[0];
  assign rd1_data_o = rd_d[1];

endmodule

// File: rtl/rot_gpr_chk.sv
module rot_gpr_chk #(
  parameter int NUM_REGS    = 128,
  parameter int STATIC_REGS = 32,
  parameter int DATA_W      = 64,
  localparam int ROT_REGS = NUM_REGS - STATIC_REGS,
  localparam int AW = $clog2(NUM_REGS),
  localparam int BW = $clog2(ROT_REGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rot,
  input logic              clr,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [AW-1:0]     rd0_addr,
  input logic [DATA_W-1:0] rd0_data,
  input logic [AW-1:0]     rd1_addr,
  input logic [DATA_W-1:0] rd1_data,
  input logic [BW-1:0]     base
);

  localparam logic [BW-1:0] TOP = BW'(ROT_REGS - 1);
  localparam logic [BW-1:0] LIM = BW'(ROT_REGS);

  p_r0_zero_rd0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_addr == '0) |-> (rd0_data == '0));

  p_r0_zero_rd1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_addr == '0) |-> (rd1_data == '0));

  p_wr_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr != '0) && !rot && !clr)
    |=> ((rd0_addr != $past(wr_addr)) || (rd0_data == $past(wr_data))));

  p_base_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rot && !clr) |=> (base == (($past(base) == TOP) ? '0 : $past(base) + 1'b1)));

  p_base_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rot && !clr) |=> $stable(base));

  p_base_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    base < LIM);

  p_base_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (base == '0));

endmodule

bind rot_gpr_file rot_gpr_chk #(
  .NUM_REGS(NUM_REGS), .STATIC_REGS(STATIC_REGS), .DATA_W(DATA_W)
) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rot     (rot_i),
  .clr     (clr_i),
  .wr_en   (wr_en_i),
  .wr_addr (wr_addr_i),
  .wr_data (wr_data_i),
  .rd0_addr(rd0_addr_i),
  .rd0_data(rd0_data_o),
  .rd1_addr(rd1_addr_i),
  .rd1_data(rd1_data_o),
  .base    (rrb)
);

// File: tb/test_rot_gpr_file.sv
`timescale 1ns/1ps
module test_rot_gpr_file;

  localparam int N  = 16;
  localparam int S  = 4;
  localparam int R  = N - S;
  localparam int W  = 16;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rot_i, clr_i, wr_en_i;
  logic [AW-1:0] wr_addr_i, rd0_addr_i, rd1_addr_i;
  logic [W-1:0]  wr_data_i, rd0_data_o, rd1_data_o;

  int n_checks = 0;
  int n_errors = 0;
  int k = 0;                 // bench view of the rotation count mod R
  logic [W-1:0] mdl [N];     // expected value per logical register

  always #4 clk = ~clk;      // 125 MHz

  rot_gpr_file #(.NUM_REGS(N), .STATIC_REGS(S), .DATA_W(W)) i_rot_gpr_file (
    .clk(clk), .rst_n(rst_n), .rot_i(rot_i), .clr_i(clr_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd0_addr_i(rd0_addr_i), .rd0_data_o(rd0_data_o),
    .rd1_addr_i(rd1_addr_i), .rd1_data_o(rd1_data_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int n, input string dflt);
    if (n == 0) return "R2";
    if (n < S)  return "R1";
    return dflt;
  endfunction

  // Shift the logical view up one rotating name (R4)
  task automatic model_rotate();
    logic [W-1:0] t [N];
    t = mdl;
    for (int i = 0; i < R; i++) mdl[S + ((i + 1) % R)] = t[S + i];
    k = (k + 1) % R;
  endtask

  // Base returns to zero from count k: logical S+j now names old physical S+j (R5)
  task automatic model_rebase();
    logic [W-1:0] t [N];
    t = mdl;
    for (int j = 0; j < R; j++) mdl[S + j] = t[S + ((j + k) % R)];
    k = 0;
  endtask

  task automatic idle();
    rot_i = 0; clr_i = 0; wr_en_i = 0;
    wr_addr_i = '0; wr_data_i = '0;
  endtask

  task automatic cyc(input logic rot, input logic clr, input logic we,
                     input int wa, input logic [W-1:0] wd);
    @(negedge clk);
    rot_i = rot; clr_i = clr; wr_en_i = we;
    wr_addr_i = AW'(wa); wr_data_i = wd;
    @(posedge clk);
    #1;
    if (we && wa != 0) mdl[wa] = wd;       // old mapping (R6)
    if (clr) model_rebase();
    else if (rot) model_rotate();
    idle();
  endtask

  task automatic check_all(input string req);
    for (int n = 0; n < N; n++) begin
      rd0_addr_i = AW'(n);
      rd1_addr_i = AW'(N - 1 - n);
      #0.2;
      check(tag_of(n, req), rd0_data_o, mdl[n]);
      check(tag_of(N - 1 - n, req), rd1_data_o, mdl[N - 1 - n]);
    end
  endtask

  function automatic logic [W-1:0] val(input int n, input int salt);
    return W'(n * 257 + salt * 4099 + 16'h1357);
  endfunction

  initial begin
    #1500000;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    idle();
    rd0_addr_i = '0; rd1_addr_i = '0;
    rst_n = 1'b0;
    for (int n = 0; n < N; n++) mdl[n] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R2 reset state: register zero reads zero on both ports
    #1;
    check("R2", rd0_data_o, '0);
    check("R2", rd1_data_o, '0);

    // Fill every logical register at base 0 (R3), then read all
    for (int n = 0; n < N; n++) cyc(0, 0, 1, n, val(n, 0));
    check_all("R3");

    // R2: a write to register zero is discarded
    cyc(0, 0, 1, 0, 16'hBEEF);
    rd0_addr_i = '0; rd1_addr_i = '0; #1;
    check("R2", rd0_data_o, '0);
    check("R2", rd1_data_o, '0);

    // R4: more than a full revolution, every name checked after each step
    for (int s = 0; s <= R; s++) begin
      cyc(1, 0, 0, 0, '0);
      check_all("R4");
    end

    // R6: write together with rotation, at various bases and names
    for (int s = 0; s < R + 2; s++) begin
      cyc(1, 0, 1, S + ((s * 5) % R), val(s, 7));
      check_all("R6");
      cyc(0, 0, 1, 1 + (s % (S - 1)), val(s, 9));   // static name (R1)
      check_all("R1");
    end

    // R7: read of the register under write returns the old value
    @(negedge clk);
    wr_en_i = 1; wr_addr_i = AW'(S + 3); wr_data_i = 16'hC0DE;
    rd0_addr_i = AW'(S + 3); rd1_addr_i = AW'(2);
    #1;
    check("R7", rd0_data_o, mdl[S + 3]);
    @(posedge clk); #1;
    mdl[S + 3] = 16'hC0DE;
    idle();
    check("R3", rd0_data_o, 16'hC0DE);

    // R8: clear at a non-zero base, with a write in the same cycle (R6)
    repeat (5) cyc(1, 0, 0, 0, '0);
    cyc(0, 1, 1, S + 1, 16'h1111);
    check_all("R8");

    // R8: clear wins over rotate
    repeat (7) cyc(1, 0, 0, 0, '0);
    cyc(1, 1, 0, 0, '0);
    check_all("R8");
    cyc(1, 0, 0, 0, '0);
    check_all("R4");

    // R9: asynchronous reset mid-run returns the base to zero
    repeat (4) cyc(1, 0, 0, 0, '0);
    @(negedge clk);
    #1 rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    model_rebase();
    check_all("R9");
    cyc(1, 0, 0, 0, '0);
    check_all("R4");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule